// File: doc/BRIEF.md
# Stop-State Release and Warm-Up Controller

This block manages a microcontroller's low-power stop state. When the CPU requests stop, the block qualifies the request against the current release mode and the stop pin, then takes the system clock enable away. It watches the synchronised stop pin for a release condition. In level mode the condition is the pin being high. In edge mode it is a rising edge. On release it starts a warm-up interval, restores the clock enable, and gives the CPU a one-cycle resume pulse.

The warm-up interval is counted in ticks of the oscillator that was driving the system clock at the moment stop began. The block captures that choice at entry and uses it whatever the system-source input does later. The length is the captured warm-up data value (zero counts as one) times 64 times 2 to the power of the captured divider field. Because the stop pin also serves as an external interrupt input, the block keeps a flag that records pin rising edges seen during stop or warm-up. Software clears it with `int_clr`.

The oscillators are modelled as one-cycle enable pulses, `fast_tick` and `slow_tick`, in the block's clock domain.

Top module: `stopwu_ctrl`

## Requirements
- R1: After reset, `sys_clk_en` is 1 and `resume`, `in_stop`, `in_warmup`, `wu_src_slow` and `int_flag` are 0.
- R2: With `rel_level`=1, a `stop_req` is ignored while the synchronised pin is high. The block stays running and `sys_clk_en` stays 1.
- R3: With `rel_level`=0, a `stop_req` enters stop whatever the pin level. `in_stop` and a low `sys_clk_en` appear one cycle after the request cycle.
- R4: In stop with `rel_level`=1, a synchronised high pin moves the block to warm-up on the next clock.
- R5: In stop with `rel_level`=0, only a rising edge of the synchronised pin releases stop. A pin that was already high at entry does not release stop.
- R6: `sys_clk_en` is 0 for every cycle in which `in_stop` or `in_warmup` is 1.
- R7: Warm-up lasts max(D,1)·64·2^V ticks of the entry oscillator. D is `wu_data` and V is `wu_div`, both captured when stop is entered.
- R8: The warm-up tick source is the value of `sys_src_slow` captured at entry (1 = slow, 0 = fast). It is shown on `wu_src_slow`, and later changes of `sys_src_slow` have no effect until the next entry.
- R9: `resume` is a single-cycle pulse in the first cycle after warm-up ends, which is the same cycle in which `sys_clk_en` returns to 1.
- R10: `int_flag` is set by a rising edge of the synchronised pin during stop or warm-up, and cleared by `int_clr`. A set in the same cycle wins over the clear.
- R11: A `wu_data` of zero gives the same warm-up length as a value of one.
- R12: `stop_req` has no effect while in stop or warm-up.
- R13: The stop pin passes through two synchroniser flops before any detection, so a pin change acts on the third clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_req | input | 1 | One-cycle stop request from the CPU |
| rel_level | input | 1 | Release mode: 1 level, 0 edge |
| stop_pin | input | 1 | Asynchronous stop/release pin |
| sys_src_slow | input | 1 | Oscillator now driving the system clock: 1 slow, 0 fast |
| wu_data | input | 8 | Warm-up count value |
| wu_div | input | 2 | Warm-up divider exponent |
| fast_tick | input | 1 | One-cycle pulse per fast-oscillator period |
| slow_tick | input | 1 | One-cycle pulse per slow-oscillator period |
| int_clr | input | 1 | Clears the latched pin-interrupt flag |
| sys_clk_en | output | 1 | System clock enable |
| resume | output | 1 | One-cycle resume pulse to the CPU |
| in_stop | output | 1 | Block is in the stop state |
| in_warmup | output | 1 | Block is counting warm-up |
| wu_src_slow | output | 1 | Oscillator captured at entry for warm-up |
| int_flag | output | 1 | Latched pin edge seen during stop or warm-up |

## Verification
The hardest situation to reach is an edge-mode stop entered while the pin is already high. Release must wait for a full low-then-high cycle of the pin, and a plain level detector would release at once. The stimulus raises the pin, waits for it to pass the synchroniser, requests stop, and holds the pin high for many cycles before dropping and raising it. A second hard case is a change of `sys_src_slow` during warm-up combined with a sparse slow tick. The stimulus flips the source input mid-interval so that a wrong source choice changes the count length. A cycle-accurate reference model then flags the difference on every clock.

// File: rtl/stopwu_pkg.sv
// Package: shared state encoding and size constants for the stop/warm-up
// controller. Assumes nothing beyond IEEE 1800-2017.
package stopwu_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_WARM = 2'd2
    } stopwu_state_e;

endpackage

// File: rtl/stopwu_sync.sv
// Module: stopwu_sync
// Multi-flop synchroniser that brings the asynchronous stop pin into the
// block clock domain. Assumes the pin is held for at least one clock period.
module stopwu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Purpose: first capture flop of the asynchronous pin
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_next
                // Purpose: further metastability-settling stage
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/stopwu_reldet.sv
// Module: stopwu_reldet
// Release detection on the synchronised pin: level or rising-edge release
// request, plus the latched pin-interrupt flag armed outside the run state.
// Assumes pin_s is already synchronous to clk.
module stopwu_reldet (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic level_mode,
    input  logic armed,
    input  logic int_clr,
    output logic pin_rise,
    output logic release_req,
    output logic int_flag
);

    logic prev_q;
    logic flag_q;

    // Purpose: remember the previous synchronised pin level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_s;
    end

    assign pin_rise    = pin_s & ~prev_q;
    assign release_req = level_mode ? pin_s : pin_rise;

    // Purpose: latch pin edges seen while stopped or warming up; set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag_q <= 1'b0;
        else if (armed && pin_rise)  flag_q <= 1'b1;
        else if (int_clr)            flag_q <= 1'b0;
    end

    assign int_flag = flag_q;

    // R10: an edge while armed must leave the flag set on the next cycle
    p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && pin_rise) |=> int_flag);

    // R10: clear without a new edge drops the flag
    p_flag_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_clr && !(armed && pin_rise)) |=> !int_flag);

endmodule

// File: rtl/stopwu_warmup.sv
// Module: stopwu_warmup
// Warm-up interval counter. On start it clears and counts the selected
// oscillator ticks until the limit max(data,1) * 2^PRESCALE_LOG2 * 2^div is
// reached, then raises done for one cycle. Assumes data/div are held stable
// by the caller while active.
module stopwu_warmup #(
    parameter int DATA_W        = 8,
    parameter int DIV_W         = 2,
    parameter int PRESCALE_LOG2 = 6,
    localparam int CNT_W        = DATA_W + PRESCALE_LOG2 + (1 << DIV_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    input  logic [DATA_W-1:0] data,
    input  logic [DIV_W-1:0]  div,
    output logic              done
);

    logic [DATA_W-1:0] eff_data;
    logic [CNT_W-1:0]  base_lim;
    logic [CNT_W-1:0]  limit;
    logic [CNT_W-1:0]  cnt_q;
    logic              active_q;

    // Purpose: zero data counts as one, then scale by prescale and divider
    always_comb begin
        eff_data = (data == '0) ? DATA_W'(1) : data;
        base_lim = CNT_W'(eff_data) << PRESCALE_LOG2;
        limit    = base_lim << div;
    end

    assign done = active_q && tick && (cnt_q == limit - CNT_W'(1));

    // Purpose: run the tick counter between start and done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (start) begin
            cnt_q    <= '0;
            active_q <= 1'b1;
        end else if (done) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (active_q && tick) begin
            cnt_q    <= cnt_q + CNT_W'(1);
        end
    end

    // R7: the count never passes the programmed limit
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (cnt_q < limit));

    // R7: completion ends the interval
    p_done_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !active_q);

endmodule

// File: rtl/stopwu_ctrl.sv
// Module: stopwu_ctrl (top)
// Stop-state controller: qualifies stop requests, gates the system clock
// enable, waits for a level or edge release on the synchronised stop pin,
// times warm-up on the oscillator captured at entry and pulses resume.
// Assumes fast_tick/slow_tick are single-cycle enables in the clk domain.
module stopwu_ctrl
    import stopwu_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int DIV_W         = 2,
    parameter int PRESCALE_LOG2 = 6,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_req,
    input  logic              rel_level,
    input  logic              stop_pin,
    input  logic              sys_src_slow,
    input  logic [DATA_W-1:0] wu_data,
    input  logic [DIV_W-1:0]  wu_div,
    input  logic              fast_tick,
    input  logic              slow_tick,
    input  logic              int_clr,
    output logic              sys_clk_en,
    output logic              resume,
    output logic              in_stop,
    output logic              in_warmup,
    output logic              wu_src_slow,
    output logic              int_flag
);

    stopwu_state_e     state_q, state_d;
    logic              pin_s;
    logic              pin_rise;
    logic              release_req;
    logic              wu_done;
    logic              wu_start;
    logic              wu_tick;
    logic              src_q;
    logic [DATA_W-1:0] data_q;
    logic [DIV_W-1:0]  div_q;
    logic              clk_en_q;
    logic              resume_q;
    logic              enter;

    stopwu_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (stop_pin),
        .sync_o  (pin_s)
    );

    stopwu_reldet u_reldet (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_s       (pin_s),
        .level_mode  (rel_level),
        .armed       (state_q != ST_RUN),
        .int_clr     (int_clr),
        .pin_rise    (pin_rise),
        .release_req (release_req),
        .int_flag    (int_flag)
    );

    assign wu_tick = src_q ? slow_tick : fast_tick;

    stopwu_warmup #(
        .DATA_W        (DATA_W),
        .DIV_W         (DIV_W),
        .PRESCALE_LOG2 (PRESCALE_LOG2)
    ) u_warmup (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wu_start),
        .tick  (wu_tick),
        .data  (data_q),
        .div   (div_q),
        .done  (wu_done)
    );

    // Purpose: entry qualification; level mode refuses entry while pin is high
    assign enter    = (state_q == ST_RUN) && stop_req && !(rel_level && pin_s);
    assign wu_start = (state_q == ST_STOP) && release_req;

    // Purpose: next-state selection of the run/stop/warm-up sequence
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (enter)       state_d = ST_STOP;
            ST_STOP: if (release_req) state_d = ST_WARM;
            ST_WARM: if (wu_done)     state_d = ST_RUN;
            default:                  state_d = ST_RUN;
        endcase
    end

    // Purpose: state, clock enable and resume pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_RUN;
            clk_en_q <= 1'b1;
            resume_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            clk_en_q <= (state_d == ST_RUN);
            resume_q <= (state_q == ST_WARM) && wu_done;
        end
    end

    // Purpose: capture warm-up source and timing settings at stop entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= 1'b0;
            data_q <= '0;
            div_q  <= '0;
        end else if (enter) begin
            src_q  <= sys_src_slow;
            data_q <= wu_data;
            div_q  <= wu_div;
        end
    end

    assign sys_clk_en  = clk_en_q;
    assign resume      = resume_q;
    assign in_stop     = (state_q == ST_STOP);
    assign in_warmup   = (state_q == ST_WARM);
    assign wu_src_slow = src_q;

    // R6: clock enable is off whenever stopped or warming up
    p_clk_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |-> !clk_en_q);

    // R9: resume lasts exactly one cycle
    p_resume_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resume_q |=> !resume_q);

    // R9: resume coincides with the clock coming back
    p_resume_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resume_q |-> (clk_en_q && state_q == ST_RUN));

    // R2: level mode with pin high keeps the block running
    p_level_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && rel_level && pin_s && !resume_q) |=> (state_q == ST_RUN));

    // R8: captured warm-up source holds while not running
    p_src_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |=> $stable(src_q));

    // R12: a request while stopped does not restart the sequence
    p_req_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WARM && !wu_done) |=> (state_q == ST_WARM));

endmodule

// File: tb/stopwu_ctrl_tb.sv
`timescale 1ns/100ps
module stopwu_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_req = 1'b0;
    logic       rel_level = 1'b0;
    logic       stop_pin = 1'b0;
    logic       sys_src_slow = 1'b0;
    logic [7:0] wu_data = 8'd1;
    logic [1:0] wu_div = 2'd0;
    logic       fast_tick = 1'b1;
    logic       slow_tick = 1'b0;
    logic       int_clr = 1'b0;
    logic       sys_clk_en, resume, in_stop, in_warmup, wu_src_slow, int_flag;

    always #2.5 clk = ~clk;

    stopwu_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .rel_level(rel_level),
        .stop_pin(stop_pin), .sys_src_slow(sys_src_slow), .wu_data(wu_data),
        .wu_div(wu_div), .fast_tick(fast_tick), .slow_tick(slow_tick),
        .int_clr(int_clr), .sys_clk_en(sys_clk_en), .resume(resume),
        .in_stop(in_stop), .in_warmup(in_warmup), .wu_src_slow(wu_src_slow),
        .int_flag(int_flag)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    string tag   = "R1";

    // Behavioural reference: 0 run, 1 stop, 2 warm-up
    int m_state = 0, m_cnt = 0, m_lim = 64;
    bit m_src = 0, m_flag = 0, m_res = 0, m_en = 1;
    bit m_s1 = 0, m_s2 = 0, m_prev = 0;

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic chk(input bit act, input bit exp, input string req, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // Reference model step using pre-edge values
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_src = 0; m_flag = 0; m_res = 0; m_en = 1;
            m_s1 = 0; m_s2 = 0; m_prev = 0;
        end else begin
            bit rise, rel, tk;
            int old_state;
            rise = m_s2 && !m_prev;
            rel  = rel_level ? m_s2 : rise;
            old_state = m_state;
            m_res = 0;
            if (old_state == 0) begin
                if (stop_req && !(rel_level && m_s2)) begin
                    m_state = 1;
                    m_src   = sys_src_slow;
                    m_lim   = ((wu_data == 0) ? 1 : int'(wu_data)) * 64 * (1 << wu_div);
                end
            end else if (old_state == 1) begin
                if (rel) begin m_state = 2; m_cnt = 0; end
            end else begin
                tk = m_src ? slow_tick : fast_tick;
                if (tk) begin
                    if (m_cnt == m_lim - 1) begin m_state = 0; m_res = 1; end
                    else m_cnt++;
                end
            end
            if (old_state != 0 && rise) m_flag = 1;
            else if (int_clr) m_flag = 0;
            m_en = (m_state == 0);
            m_prev = m_s2; m_s2 = m_s1; m_s1 = stop_pin;
        end
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    // Compare every output against the model away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(sys_clk_en, m_en, "R6", "sys_clk_en");
            chk(resume, m_res, "R9", "resume");
            chk(in_stop, m_state == 1, tag, "in_stop");
            chk(in_warmup, m_state == 2, tag, "in_warmup");
            chk(wu_src_slow, m_src, "R8", "wu_src_slow");
            chk(int_flag, m_flag, "R10", "int_flag");
        end
    end

    // Slow-oscillator tick every third cycle
    int slow_div = 0;
    always @(negedge clk) begin
        #1;
        slow_div = (slow_div == 2) ? 0 : slow_div + 1;
        slow_tick = (slow_div == 0);
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic pulse_req();
        stop_req = 1'b1; step(1); stop_req = 1'b0;
    endtask

    task automatic wait_resume(input int maxc);
        for (int i = 0; i < maxc; i++) begin
            if (resume === 1'b1) break;
            step(1);
        end
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1: reset values
        chk(sys_clk_en, 1'b1, "R1", "reset sys_clk_en");
        chk(in_stop | in_warmup | resume | int_flag | wu_src_slow, 1'b0, "R1", "reset outputs");

        // R2: level mode, pin high -> request refused
        tag = "R2"; rel_level = 1'b1; stop_pin = 1'b1; step(4);
        pulse_req(); step(2);
        chk(in_stop, 1'b0, "R2", "level refuse in_stop");
        chk(sys_clk_en, 1'b1, "R2", "level refuse clk_en");

        // R4 R13: level mode entry with pin low, release by pin high, 64 fast ticks
        tag = "R4"; stop_pin = 1'b0; step(4);
        wu_data = 8'd1; wu_div = 2'd0; pulse_req();
        chk(in_stop, 1'b1, "R4", "level entry");
        // R12: second request while stopped is ignored
        pulse_req(); chk(in_stop, 1'b1, "R12", "req in stop");
        stop_pin = 1'b1; step(2);
        chk(in_stop, 1'b1, "R13", "two-flop delay still stopped");
        step(1);
        chk(in_warmup, 1'b1, "R4", "level release");
        tag = "R7"; stop_pin = 1'b0;
        step(63);
        chk(in_warmup, 1'b1, "R7", "warm-up still running at 63");
        step(1);
        chk(resume, 1'b1, "R9", "resume after 64 ticks");
        step(1);
        chk(resume, 1'b0, "R9", "resume single cycle");

        // R3 R5: edge mode, pin high at entry; no release until low then high
        tag = "R5"; rel_level = 1'b0; stop_pin = 1'b1; step(4);
        sys_src_slow = 1'b1; wu_data = 8'd0; wu_div = 2'd1; pulse_req();
        chk(in_stop, 1'b1, "R3", "edge entry with pin high");
        step(20);
        chk(in_stop, 1'b1, "R5", "held-high pin no release");
        int_clr = 1'b1; step(1); int_clr = 1'b0;
        stop_pin = 1'b0; step(4); stop_pin = 1'b1; step(4);
        chk(in_warmup, 1'b1, "R5", "rising edge release");
        chk(int_flag, 1'b1, "R10", "edge during stop sets flag");
        // R8: source input changes mid warm-up, captured slow stays in use (R11: data 0)
        tag = "R11"; sys_src_slow = 1'b0;
        stop_pin = 1'b0; step(3); stop_pin = 1'b1; step(3);
        int_clr = 1'b1; step(1); int_clr = 1'b0;
        chk(wu_src_slow, 1'b1, "R8", "captured source kept");
        wait_resume(500);
        chk(resume, 1'b1, "R11", "data zero warm-up ends");
        step(1);
        int_clr = 1'b1; step(1); int_clr = 1'b0;
        chk(int_flag, 1'b0, "R10", "flag cleared");

        // R7: data 2, div 2, fast source -> 512 ticks
        tag = "R7"; stop_pin = 1'b0; step(4);
        wu_data = 8'd2; wu_div = 2'd2; pulse_req();
        stop_pin = 1'b1; step(4);
        chk(in_warmup, 1'b1, "R7", "edge release fast");
        wait_resume(600);
        chk(resume, 1'b1, "R7", "long warm-up ends");
        step(5);
        report();
    end

endmodule